// File: doc/BRIEF.md
# Dual-Mode SD Card Clock Divider

This block derives the SD card clock from the core clock. An 11-bit divisor register holds the divide ratio minus two, so a stored code `c` produces one output period every `c + 2` core cycles. Code zero divides by two, and the largest code, 0x7FF, gives the slowest clock. No code stops the clock.

A mode input selects between identification and data operation. In identification mode the whole 11-bit code sets the ratio. In data mode only the three low bits of the code apply, which gives fast ratios between 2 and 9. A slow-card input forces the full 11-bit code in both modes. Odd ratios give a high phase one core cycle longer than the low phase. A change to the code, the mode or the slow-card input waits for the next rising edge of the output, so no shortened pulse appears.

Top module: `sd_clk_div`

## Requirements
- R1: While reset is low, `sd_clk` is 0 and `div_reg` reads 0x7FF. On the first core clock edge after reset is released, `sd_clk` rises.
- R2: A core clock edge with `div_wr` high loads `div_wdata` into the divisor register, and `div_reg` shows the new value after that edge. With `div_wr` low, the register holds its value.
- R3: With `data_mode` at 0 (identification), each output period lasts code + 2 core cycles, using all 11 bits of the code.
- R4: With `data_mode` at 1 and `slow_card` at 0, each output period lasts code[2:0] + 2 core cycles, and code bits 10:3 have no effect.
- R5: With `slow_card` at 1, each output period lasts code + 2 core cycles in both modes.
- R6: Each period of ratio N starts with a high phase of ceil(N/2) core cycles, followed by a low phase of floor(N/2) core cycles.
- R7: A new code, mode or slow-card value first applies to the period that starts at the next rising edge of `sd_clk`. The period in progress keeps its high and low lengths.
- R8: Code 0x7FF gives the slowest clock, a period of 2049 core cycles (1025 high, 1024 low), and the output keeps toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Write strobe for the divisor register |
| div_wdata | input | 11 | Divisor code (ratio minus two) |
| data_mode | input | 1 | 0 = identification mode, 1 = data mode |
| slow_card | input | 1 | Forces the full 11-bit divisor in every mode |
| div_reg | output | 11 | Current divisor register contents |
| sd_clk | output | 1 | Generated SD card clock |

## Verification
A register write appears on `div_reg` one core cycle after the strobe. A new ratio appears only at the rising edge of `sd_clk` that ends the current period, because `sd_clk` is registered and changes one cycle after the counter wraps. The bench drives inputs and samples outputs on falling core clock edges, so each sample covers one core cycle. After every configuration change it lets one rising edge pass before it measures the high and low runs of the next full period. The mid-period tests measure the period in which the change occurs and the period that follows it, to confirm that the change waits for the boundary.

// File: rtl/sd_clk_div.sv
module sd_clk_div #(
  parameter int DIV_W     = 11,
  parameter int DATA_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             data_mode,
  input  logic             slow_card,
  output logic [DIV_W-1:0] div_reg,
  output logic             sd_clk
);
  localparam int RW = DIV_W + 1;
  localparam logic [RW-1:0] RATIO_MAX = {1'b0, {DIV_W{1'b1}}} + RW'(2);

  logic [DIV_W-1:0] div_q, eff;
  logic [RW-1:0]    ratio_q, cnt_q, cnt_n, ratio_n, next_ratio, hi_n;
  logic             wrap, clk_q;

  assign eff        = (data_mode && !slow_card)
                    ? {{(DIV_W-DATA_BITS){1'b0}}, div_q[DATA_BITS-1:0]} : div_q;
  assign next_ratio = {1'b0, eff} + RW'(2);
  assign wrap       = (cnt_q == ratio_q - RW'(1));
  assign cnt_n      = wrap ? '0 : cnt_q + RW'(1);
  assign ratio_n    = wrap ? next_ratio : ratio_q;
  assign hi_n       = ratio_n - (ratio_n >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '1;
      ratio_q <= RATIO_MAX;
      cnt_q   <= RATIO_MAX - RW'(1);
      clk_q   <= 1'b0;
    end else begin
      if (div_wr) div_q <= div_wdata;
      ratio_q <= ratio_n;
      cnt_q   <= cnt_n;
      clk_q   <= (cnt_n < hi_n);
    end
  end

  assign div_reg = div_q;
  assign sd_clk  = clk_q;
endmodule

// File: rtl/sd_clk_div_chk.sv
module sd_clk_div_chk #(
  parameter int DIV_W     = 11,
  parameter int DATA_BITS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_wr,
  input logic [DIV_W-1:0] div_wdata,
  input logic [DIV_W-1:0] div_reg,
  input logic             sd_clk
);
  localparam int MAX_RUN = (1 << (DIV_W - 1)) + 1;

  logic         prev_q;
  logic [DIV_W:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= sd_clk;
      if (sd_clk != prev_q) run_q <= (DIV_W+1)'(1);
      else if (run_q != '1) run_q <= run_q + 1'b1;
    end
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (div_reg == {DIV_W{1'b1}} && !sd_clk));

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (div_reg == $past(div_wdata)));

  assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wr |=> $stable(div_reg));

  assert_phase_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= (DIV_W+1)'(MAX_RUN));
endmodule

bind sd_clk_div sd_clk_div_chk #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
  .div_reg(div_reg), .sd_clk(sd_clk)
);

// File: tb/test_sd_clk_div.sv
module test_sd_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_wr = 1'b0;
  logic [10:0] div_wdata = '0;
  logic        data_mode = 1'b0;
  logic        slow_card = 1'b0;
  logic [10:0] div_reg;
  logic        sd_clk;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  sd_clk_div i_sd_clk_div (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .data_mode(data_mode), .slow_card(slow_card), .div_reg(div_reg), .sd_clk(sd_clk)
  );

  function automatic int exp_ratio(int code, bit mode, bit slow);
    return ((mode && !slow) ? (code & 7) : code) + 2;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_rise();
    bit p;
    do begin p = sd_clk; step(); end while (!(p == 1'b0 && sd_clk == 1'b1));
  endtask

  task automatic measure(bit sync, output int hi, output int lo);
    if (sync) wait_rise();
    hi = 0; lo = 0;
    while (sd_clk) begin hi++; step(); end
    while (!sd_clk) begin lo++; step(); end
  endtask

  task automatic configure(int code, bit mode, bit slow);
    div_wr = 1'b1; div_wdata = 11'(code); data_mode = mode; slow_card = slow;
    step();
    div_wr = 1'b0;
    check(div_reg == 11'(code), "R2 divisor load", int'(div_reg), code);
  endtask

  task automatic check_period(int code, bit mode, bit slow, string tag);
    int hi, lo, n;
    configure(code, mode, slow);
    wait_rise();
    measure(1'b1, hi, lo);
    n = exp_ratio(code, mode, slow);
    check(hi == n - n / 2, {tag, " high"}, hi, n - n / 2);
    check(lo == n / 2, {tag, " low"}, lo, n / 2);
  endtask

  initial begin
    #(8 * 190000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hi, lo;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) step();
    check(sd_clk == 1'b0, "R1 clock low in reset", int'(sd_clk), 0);
    check(div_reg == 11'h7FF, "R1 reset divisor", int'(div_reg), 2047);
    rst_n = 1'b1;
    step();
    check(sd_clk == 1'b1, "R1 first rise after reset", int'(sd_clk), 1);
    measure(1'b0, hi, lo);
    check(hi == 1025, "R8 slowest high", hi, 1025);
    check(lo == 1024, "R8 slowest low", lo, 1024);

    check_period(623, 1'b0, 1'b0, "R3 ident 623");
    check_period(0, 1'b0, 1'b0, "R3 ident 0");
    check_period(12'h0FD, 1'b1, 1'b0, "R4 data low bits");
    check_period(7, 1'b1, 1'b0, "R4 data code 7");
    check_period(12'h0FD, 1'b1, 1'b1, "R5 slow card data mode");
    check_period(4, 1'b0, 1'b1, "R5 slow card ident");
    check_period(1, 1'b0, 1'b0, "R6 odd ratio 3");
    check_period(2, 1'b1, 1'b0, "R6 even ratio 4");

    // R7: divisor write in the middle of a high phase
    configure(20, 1'b0, 1'b0);
    wait_rise();
    hi = 0; lo = 0;
    while (sd_clk) begin
      hi++;
      if (hi == 3) begin div_wr = 1'b1; div_wdata = 11'd0; end
      else div_wr = 1'b0;
      step();
    end
    div_wr = 1'b0;
    while (!sd_clk) begin lo++; step(); end
    check(hi == 11 && lo == 11, "R7 write keeps current period", hi + lo, 22);
    measure(1'b0, hi, lo);
    check(hi == 1 && lo == 1, "R7 write applies next period", hi + lo, 2);

    // R7: mode switch in the middle of a high phase
    configure(12'h0F9, 1'b0, 1'b0);
    wait_rise();
    hi = 0; lo = 0;
    while (sd_clk) begin
      hi++;
      if (hi == 5) data_mode = 1'b1;
      step();
    end
    while (!sd_clk) begin lo++; step(); end
    check(hi == 126 && lo == 125, "R7 mode keeps current period", hi + lo, 251);
    measure(1'b0, hi, lo);
    check(hi == 2 && lo == 1, "R7 mode applies next period", hi + lo, 3);

    for (int i = 0; i < 25; i++) begin
      int code;
      bit m, s;
      code = ($urandom % 2) ? int'($urandom % 300) : int'($urandom % 2048);
      m = 1'($urandom % 2);
      s = 1'($urandom % 4 == 0);
      if (!m || s) code = code % 300;
      check_period(code, m, s, "R3/R4/R5/R6 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule